// File: doc/BRIEF.md
# Burst-Mode FFT Frame Sequencer

This block sets the order of the three phases of a burst-mode transform. It first collects a whole input frame into the frame memory. It then hands the frame to a butterfly engine and waits for the engine to finish. Last, it streams the results back out. It produces the write-side and read-side addresses of the frame memory and the start pulse for the engine, and it takes the engine's completion strobe back in. The arithmetic is not part of this block. In the bench, the engine is a stub with a fixed latency.

A frame holds 2^L points, with L between 6 and 16. The value of L and the output-order mode are captured when a frame is started, and they stay fixed for that frame. Sample input and result output are both locked out while the engine runs. Results can come out in natural order or in radix-4 digit-reversed order. In digit-reversed order, the next frame may load while the current one is still unloading: new sample k goes into the slot that output k is read from, in the same cycle or a later one. A read-first frame memory therefore always returns the old value before it is overwritten.

Top module: `burst_fft_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, load_ready_o, mem_we_o, mem_re_o, out_valid_o and eng_start_o are all 0.
- R2: A start_i that is accepted captures the size L = clamp(log2n_i, 6, 16) and the mode out_digrev_i (1 = digit-reversed output), and load_ready_o goes high in the next cycle. Changes to log2n_i or out_digrev_i after that cycle do not affect the frame.
- R3: Each cycle with in_valid_i and load_ready_o both high asserts mem_we_o, with mem_waddr_o equal to the number of samples already taken in this frame. In the cycle after the 2^L-th sample, load_ready_o is 0 and eng_start_o is high for exactly one cycle, unless R9 applies.
- R4: From the eng_start_o cycle until the engine finishes, load_ready_o, mem_we_o and out_valid_o stay 0. Any in_valid_i or start_i seen in that time is ignored.
- R5: eng_done_i seen while the engine runs makes out_valid_o and mem_re_o high from the next cycle on, for exactly 2^L consecutive cycles. eng_done_i seen at any other time is ignored.
- R6: Let output step k run from 0 to 2^L-1. With mode 0, out_index_o = k and mem_raddr_o = rev(k). With mode 1, out_index_o = rev(k) and mem_raddr_o = k.
- R7: rev(k) takes the low L bits of k as base-4 digits d0 (least significant) up to d(m-1), where m = floor(L/2), plus one top bit b when L is odd. The result is r = d0·4^(m-1) + d1·4^(m-2) + … + d(m-1), and when L is odd it becomes 2r + b.
- R8: With mode 1, a start_i during unloading is accepted and the new frame loads at the same time. Every write then has mem_waddr_o ≤ mem_raddr_o.
- R9: If an overlapped frame is fully loaded before unloading ends, load_ready_o and eng_start_o stay 0 until then. eng_start_o rises in the cycle after the last out_valid_o.
- R10: With mode 0, a start_i during unloading is ignored, and no load is taken until a new start_i after unloading ends.
- R11: A start_i while a frame is loading is ignored. The sample count and the captured size carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin loading a new frame |
| log2n_i | input | 5 | Frame size as log2 of the point count, clamped to 6..16 |
| out_digrev_i | input | 1 | Output order: 0 natural, 1 radix-4 digit-reversed |
| in_valid_i | input | 1 | An input sample is present this cycle |
| eng_done_i | input | 1 | Butterfly engine has finished the frame |
| load_ready_o | output | 1 | Input samples are being accepted |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_waddr_o | output | 16 | Frame memory write address |
| mem_re_o | output | 1 | Frame memory read enable |
| mem_raddr_o | output | 16 | Frame memory read address |
| out_valid_o | output | 1 | A result sample is delivered this cycle |
| out_index_o | output | 16 | Frequency index of the delivered result |
| eng_start_o | output | 1 | One-cycle start pulse to the butterfly engine |

## Verification
Frames are run over a table of sizes, both output modes, clamped-low sizes, and input that is either back-to-back or has a gap in every other cycle. This shows that the write count follows accepted samples and not cycles, and that the digit-reversal index is right for both even and odd L. Stray start and valid pulses are sent during compute and during loading, and so is a late change of size and mode, to show that the captured frame settings hold. One unload in digit-reversed mode gets a smaller frame started partway through. This separates a true overlap with a delayed engine start from the natural-order case, where the same request must be dropped.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    localparam int PKG_AW = 16;
    localparam int PKG_LW = 5;

    typedef enum logic [1:0] {
        L_IDLE = 2'd0,
        L_LOAD = 2'd1,
        L_FULL = 2'd2
    } load_st_e;

    typedef enum logic {
        E_IDLE = 1'b0,
        E_RUN  = 1'b1
    } eng_st_e;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_RUN  = 1'b1
    } unl_st_e;

    typedef struct packed {
        logic [PKG_LW-1:0] log2n;
        logic              digrev;
    } frame_cfg_t;

    function automatic logic [PKG_LW-1:0] clamp_log2(
        input logic [PKG_LW-1:0] v, input int lo, input int hi);
        if (int'(v) < lo)      return PKG_LW'(lo);
        else if (int'(v) > hi) return PKG_LW'(hi);
        else                   return v;
    endfunction

    function automatic logic [PKG_AW-1:0] last_idx(input logic [PKG_LW-1:0] l2);
        return {PKG_AW{1'b1}} >> (PKG_AW - int'(l2));
    endfunction

    function automatic logic [PKG_AW-1:0] digit_rev(
        input logic [PKG_AW-1:0] idx, input logic [PKG_LW-1:0] l2);
        logic [PKG_AW-1:0] r;
        logic [PKG_AW-1:0] x;
        r = '0;
        x = idx;
        for (int i = 0; i < PKG_AW / 2; i++) begin
            if (2 * i + 2 <= int'(l2)) begin
                r = {r[PKG_AW-3:0], x[1:0]};
                x = x >> 2;
            end else if (2 * i + 1 == int'(l2)) begin
                r = {r[PKG_AW-2:0], x[0]};
                x = x >> 1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/bfs_load_ctl.sv
module bfs_load_ctl
    import bfs_pkg::*;
#(
    parameter int AW       = 16,
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic [PKG_LW-1:0] log2n_in,
    input  logic              digrev_in,
    input  logic              in_valid,
    input  logic              release_go,
    output logic              idle,
    output logic              full,
    output logic              ready,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output frame_cfg_t        cfg
);

    load_st_e      state;
    logic [AW-1:0] cnt;
    logic [AW-1:0] lim;

    assign lim   = AW'(last_idx(cfg.log2n));
    assign idle  = (state == L_IDLE);
    assign full  = (state == L_FULL);
    assign ready = (state == L_LOAD);
    assign we    = ready && in_valid;
    assign waddr = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= L_IDLE;
            cnt   <= '0;
            cfg   <= '0;
        end else begin
            case (state)
                L_IDLE: begin
                    if (start_ok) begin
                        state     <= L_LOAD;
                        cnt       <= '0;
                        cfg.log2n <= clamp_log2(log2n_in, MIN_LOG2, MAX_LOG2);
                        cfg.digrev <= digrev_in;
                    end
                end
                L_LOAD: begin
                    if (in_valid) begin
                        if (cnt == lim) begin
                            state <= L_FULL;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                L_FULL: begin
                    if (release_go) state <= L_IDLE;
                end
                default: state <= L_IDLE;
            endcase
        end
    end

    AST_LOAD_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cnt <= lim)) else $error("load index past frame end"); // R3

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> $stable(cfg)) else $error("size changed mid-load"); // R11

endmodule

// File: rtl/bfs_eng_ctl.sv
module bfs_eng_ctl
    import bfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic done_in,
    output logic busy,
    output logic done_ok
);

    eng_st_e state;

    assign busy    = (state == E_RUN);
    assign done_ok = busy && done_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= E_IDLE;
        end else begin
            case (state)
                E_IDLE:  if (go)      state <= E_RUN;
                E_RUN:   if (done_in) state <= E_IDLE;
                default: state <= E_IDLE;
            endcase
        end
    end

    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy) else $error("engine started twice"); // R4

endmodule

// File: rtl/bfs_unload_ctl.sv
module bfs_unload_ctl
    import bfs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  frame_cfg_t    cfg_in,
    output logic          active,
    output logic          digrev,
    output logic          valid,
    output logic [AW-1:0] index,
    output logic [AW-1:0] raddr
);

    unl_st_e       state;
    frame_cfg_t    cfg;
    logic [AW-1:0] cnt;
    logic [AW-1:0] lim;
    logic [AW-1:0] rev;

    assign lim    = AW'(last_idx(cfg.log2n));
    assign rev    = AW'(digit_rev(PKG_AW'(cnt), cfg.log2n));
    assign active = (state == U_RUN);
    assign digrev = cfg.digrev;
    assign valid  = active;
    assign index  = cfg.digrev ? rev : cnt;
    assign raddr  = cfg.digrev ? cnt : rev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= U_IDLE;
            cfg   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                U_IDLE: begin
                    if (launch) begin
                        state <= U_RUN;
                        cfg   <= cfg_in;
                        cnt   <= '0;
                    end
                end
                U_RUN: begin
                    if (cnt == lim) begin
                        state <= U_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= U_IDLE;
            endcase
        end
    end

    AST_UNLOAD_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid |-> (index <= lim && raddr <= lim)) else $error("unload index out of frame"); // R6

endmodule

// File: rtl/burst_fft_sequencer.sv
module burst_fft_sequencer
    import bfs_pkg::*;
#(
    parameter int MIN_LOG2 = 6,
    parameter int MAX_LOG2 = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [PKG_LW-1:0]   log2n_i,
    input  logic                out_digrev_i,
    input  logic                in_valid_i,
    input  logic                eng_done_i,
    output logic                load_ready_o,
    output logic                mem_we_o,
    output logic [MAX_LOG2-1:0] mem_waddr_o,
    output logic                mem_re_o,
    output logic [MAX_LOG2-1:0] mem_raddr_o,
    output logic                out_valid_o,
    output logic [MAX_LOG2-1:0] out_index_o,
    output logic                eng_start_o
);

    localparam int AW = MAX_LOG2;

    logic       ld_idle, ld_full;
    logic       eng_busy, eng_done_ok;
    logic       unl_active, unl_digrev;
    logic       start_ok;
    frame_cfg_t ld_cfg;

    assign start_ok    = start_i && ld_idle && !eng_busy && (!unl_active || unl_digrev);
    assign eng_start_o = ld_full && !eng_busy && !unl_active;
    assign mem_re_o    = out_valid_o;

    bfs_load_ctl #(.AW(AW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_load (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (start_ok),
        .log2n_in   (log2n_i),
        .digrev_in  (out_digrev_i),
        .in_valid   (in_valid_i),
        .release_go (eng_start_o),
        .idle       (ld_idle),
        .full       (ld_full),
        .ready      (load_ready_o),
        .we         (mem_we_o),
        .waddr      (mem_waddr_o),
        .cfg        (ld_cfg)
    );

    bfs_eng_ctl u_eng (
        .clk     (clk),
        .rst     (rst),
        .go      (eng_start_o),
        .done_in (eng_done_i),
        .busy    (eng_busy),
        .done_ok (eng_done_ok)
    );

    bfs_unload_ctl #(.AW(AW)) u_unl (
        .clk    (clk),
        .rst    (rst),
        .launch (eng_done_ok),
        .cfg_in (ld_cfg),
        .active (unl_active),
        .digrev (unl_digrev),
        .valid  (out_valid_o),
        .index  (out_index_o),
        .raddr  (mem_raddr_o)
    );

    AST_COMPUTE_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> (!load_ready_o && !mem_we_o && !out_valid_o)) else $error("I/O during compute"); // R4

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o) else $error("engine start longer than one cycle"); // R3

    AST_UNLOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid_o) |-> $past(eng_done_i)) else $error("unload began without done"); // R5

    AST_OVERLAP_SAFE: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && out_valid_o) |-> (mem_waddr_o <= mem_raddr_o)) else $error("slot overwritten before read"); // R8

    AST_NATURAL_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && out_valid_o) |-> unl_digrev) else $error("overlap in natural order"); // R10

endmodule

// File: tb/sim_burst_fft_sequencer.sv
`timescale 1ns/1ps
module sim_burst_fft_sequencer;

    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [4:0]  log2n_i = 5'd6;
    logic        out_digrev_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        eng_done_i;
    logic        xdone = 1'b0;
    logic        load_ready_o, mem_we_o, mem_re_o, out_valid_o, eng_start_o;
    logic [15:0] mem_waddr_o, mem_raddr_o, out_index_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    logic [7:0] stub_cnt;
    always_ff @(posedge clk) begin
        if (rst) stub_cnt <= '0;
        else if (eng_start_o) stub_cnt <= 8'(LAT);
        else if (stub_cnt != 0) stub_cnt <= stub_cnt - 1'b1;
    end
    assign eng_done_i = (stub_cnt == 8'd1) || xdone;

    burst_fft_sequencer u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .log2n_i(log2n_i),
        .out_digrev_i(out_digrev_i), .in_valid_i(in_valid_i), .eng_done_i(eng_done_i),
        .load_ready_o(load_ready_o), .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o),
        .mem_re_o(mem_re_o), .mem_raddr_o(mem_raddr_o), .out_valid_o(out_valid_o),
        .out_index_o(out_index_o), .eng_start_o(eng_start_o)
    );

    // [6:2] requested log2 size, [1] output mode, [0] gap between samples
    localparam logic [6:0] VEC [5] = '{
        {5'd6, 1'b0, 1'b0},
        {5'd7, 1'b1, 1'b1},
        {5'd8, 1'b1, 1'b0},
        {5'd3, 1'b0, 1'b1},
        {5'd9, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampl(input int v);
        return (v < 6) ? 6 : ((v > 16) ? 16 : v);
    endfunction

    function automatic int bref(input int k, input int l);
        int r = 0;
        int x = k;
        for (int i = 0; i < l / 2; i++) begin
            r = r * 4 + x % 4;
            x = x / 4;
        end
        if (l % 2 == 1) r = r * 2 + x % 2;
        return r;
    endfunction

    task automatic do_load(input int lin, input bit mode, input bit gap);
        int l = clampl(lin);
        int n = 1 << l;
        @(negedge clk);
        start_i = 1'b1; log2n_i = 5'(lin); out_digrev_i = mode; in_valid_i = 1'b0;
        #1 chk(!load_ready_o, "R2 ready before accept", int'(load_ready_o), 0);
        @(negedge clk);
        start_i = 1'b0; log2n_i = 5'd12; out_digrev_i = !mode;   // late change, R2
        for (int k = 0; k < n; k++) begin
            if (gap && (k % 2 == 1)) begin
                in_valid_i = 1'b0;
                #1 chk(!mem_we_o && load_ready_o, "R3 no write in gap", int'(mem_we_o), 0);
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            start_i = (k == 3);   // R11 restart attempt
            #1 chk(load_ready_o && mem_we_o && int'(mem_waddr_o) == k,
                   "R3 R11 write address", int'(mem_waddr_o), k);
            @(negedge clk);
        end
        in_valid_i = 1'b1; start_i = 1'b1;
        #1 chk(eng_start_o && !load_ready_o && !mem_we_o, "R3 engine start after frame",
               int'(eng_start_o), 1);
    endtask

    task automatic do_compute();
        int n = 0;
        bit pd = 0;
        forever begin
            @(negedge clk);
            in_valid_i = 1'b1;
            start_i = (n < 3);
            #1;
            if (out_valid_o) break;
            chk(!load_ready_o && !mem_we_o && !eng_start_o, "R4 lockout in compute",
                int'(load_ready_o), 0);
            pd = eng_done_i;
            n++;
            if (n > 200) begin
                chk(1'b0, "R5 unload never began", 0, 1);
                break;
            end
        end
        chk(pd, "R5 unload one cycle after done", int'(pd), 1);
        start_i = 1'b0; in_valid_i = 1'b0;
        #1;
    endtask

    task automatic do_unload(input int l, input bit mode, input int ov_at,
                             input int ovl, input bit ovmode);
        int n = 1 << l;
        int nn = 1 << ovl;
        int j = 0;
        for (int k = 0; k < n; k++) begin
            bit tried = (ov_at >= 0) && (k > ov_at);
            int eidx = mode ? bref(k, l) : k;
            int eadr = mode ? k : bref(k, l);
            start_i = (k == ov_at); log2n_i = 5'(ovl); out_digrev_i = ovmode;
            in_valid_i = tried;
            #1;
            chk(out_valid_o && mem_re_o, "R5 unload valid", int'(out_valid_o), 1);
            chk(int'(out_index_o) == eidx, "R6 R7 output index", int'(out_index_o), eidx);
            chk(int'(mem_raddr_o) == eadr, "R6 R7 read address", int'(mem_raddr_o), eadr);
            if (tried && mode) begin
                if (j < nn) begin
                    chk(load_ready_o && mem_we_o && int'(mem_waddr_o) == j
                        && mem_waddr_o <= mem_raddr_o, "R8 overlapped write",
                        int'(mem_waddr_o), j);
                    j++;
                end else begin
                    chk(!load_ready_o && !eng_start_o, "R9 wait for unload end",
                        int'(eng_start_o), 0);
                end
            end else if (tried) begin
                chk(!load_ready_o && !mem_we_o, "R10 natural start ignored",
                    int'(load_ready_o), 0);
            end else begin
                chk(!mem_we_o, "R5 no write during unload", int'(mem_we_o), 0);
            end
            @(negedge clk);
        end
        start_i = 1'b0; in_valid_i = 1'b0;
        #1 chk(!out_valid_o, "R5 exactly N outputs", int'(out_valid_o), 0);
        if (ov_at >= 0 && mode)
            chk(eng_start_o, "R9 start after last output", int'(eng_start_o), 1);
        else if (ov_at >= 0)
            chk(!load_ready_o, "R10 no load after natural unload", int'(load_ready_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(!load_ready_o && !mem_we_o && !mem_re_o && !out_valid_o && !eng_start_o,
               "R1 outputs in reset", int'(load_ready_o), 0);
        @(negedge clk);
        rst = 1'b0;
        #1 chk(!load_ready_o && !mem_we_o && !mem_re_o && !out_valid_o && !eng_start_o,
               "R1 outputs after reset", int'(out_valid_o), 0);

        // stray engine completion while idle
        @(negedge clk);
        xdone = 1'b1;
        @(negedge clk);
        xdone = 1'b0;
        #1 chk(!out_valid_o, "R5 stray done ignored", int'(out_valid_o), 0);

        // table of frames
        for (int v = 0; v < 5; v++) begin
            int lin = int'(VEC[v][6:2]);
            bit md = VEC[v][1];
            bit gp = VEC[v][0];
            do_load(lin, md, gp);
            do_compute();
            do_unload(clampl(lin), md, -1, 6, 1'b0);
        end

        // overlap in digit-reversed order with a smaller next frame
        do_load(8, 1'b1, 1'b0);
        do_compute();
        do_unload(8, 1'b1, 10, 6, 1'b0);
        do_compute();
        do_unload(6, 1'b0, -1, 6, 1'b0);

        // natural order: start during unload must be dropped
        do_load(6, 1'b0, 1'b0);
        do_compute();
        do_unload(6, 1'b0, 5, 7, 1'b1);
        @(negedge clk);
        #1 chk(!load_ready_o && !eng_start_o, "R10 still idle", int'(load_ready_o), 0);

        // clean start after the dropped request
        do_load(7, 1'b1, 1'b0);
        do_compute();
        do_unload(7, 1'b1, -1, 6, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule